// File: doc/BRIEF.md
# Modulo 2^n-1 Residue Adder with Excess-One Correction

This block adds two n-bit residues modulo 2^n-1 and returns a residue that never uses the all-ones pattern for zero. It is purely combinational. A parallel-prefix carry network first forms the plain n-bit binary sum of the two operands. A conditional-increment stage then corrects that sum. The increment decision comes from two signals the prefix network already holds: the group generate over all n bits, which is the carry-out, and the group propagate over all n bits, which flags an all-ones sum. So the block needs no extra prefix level for the end-around carry and no separate all-ones detector.

The width and the prefix topology are parameters. The topology is either a Brent-Kung tree (fewer nodes, deeper) or a Ladner-Fischer tree (minimum depth, higher fan-out). Both give the same result. The block is meant to be the final two-operand adder of a residue-to-binary converter, or any other datapath that needs one modulo 2^n-1 addition.

Top module: `mres_add`

## Requirements
- R1: For operands in 0..2^n-2, `res_o` equals (opa_i + opb_i) mod (2^n-1).
- R2: `res_o` is never all ones unless both operands are all ones.
- R3: When opa_i + opb_i equals exactly 2^n-1, `res_o` is all zeros.
- R4: When opa_i + opb_i is 2^n or more (carry-out of the n-bit sum), `res_o` equals opa_i + opb_i - (2^n-1).
- R5: When opa_i + opb_i is below 2^n-1, `res_o` equals the plain binary sum.
- R6: When exactly one operand is all ones (the alternate encoding of zero), `res_o` equals the other operand, with zero written as all zeros.
- R7: TOPOLOGY = TOPO_BRENT_KUNG (0) and TOPOLOGY = TOPO_LADNER_FISCHER (1) give identical outputs for identical inputs.
- R8: Adding zero is the identity, and 0 + 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | First residue operand |
| opb_i | input | WIDTH | Second residue operand |
| res_o | output | WIDTH | Sum modulo 2^WIDTH-1, with a single encoding of zero |

## Verification
The bench builds the adder at WIDTH 4 and WIDTH 5, each in both topologies, and at WIDTH 16 (Ladner-Fischer) and WIDTH 32 (both topologies). At widths 4 and 5 every valid operand pair is applied, so each of the three correction cases (carry-out, exact all-ones sum, pass-through) is covered in full. Width 5 is not a power of two, so it exercises the trees' handling of a partial top level. The wide builds reach the long carry chains through random pairs and directed corner pairs, such as maximum plus maximum and sums that land exactly on 2^n-1.

// File: rtl/mres_pkg.sv
package mres_pkg;

   typedef enum logic [0:0] {
      TOPO_BRENT_KUNG     = 1'b0,
      TOPO_LADNER_FISCHER = 1'b1
   } topo_e;

   function automatic int clog2_min1(input int value);
      int r;
      r = 0;
      while ((1 << r) < value) r++;
      return (r < 1) ? 1 : r;
   endfunction

endpackage

// File: rtl/mres_prefix_tree.sv
module mres_prefix_tree
   import mres_pkg::*;
#(
   parameter int    WIDTH    = 16,
   parameter topo_e TOPOLOGY = TOPO_BRENT_KUNG
) (
   input  logic [WIDTH-1:0] gen_i,
   input  logic [WIDTH-1:0] prop_i,
   output logic [WIDTH-1:0] carry_o,
   output logic             prop_all_o
);

   localparam int LVLS = clog2_min1(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("mres_prefix_tree: WIDTH must be at least 2");
   end

   if (TOPOLOGY == TOPO_BRENT_KUNG) begin : g_bk
      localparam int NST = 2 * LVLS - 1;
      logic [WIDTH-1:0] gs [NST+1];
      logic [WIDTH-1:0] ps [NST+1];

      assign gs[0] = gen_i;
      assign ps[0] = prop_i;

      for (genvar s = 0; s < NST; s++) begin : g_stage
         localparam bit UP = (s < LVLS);
         localparam int LV = UP ? s : (2 * LVLS - 2 - s);
         localparam int D  = 1 << LV;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam bit ACT = UP ? (((i + 1) % (2 * D)) == 0)
                                    : ((((i + 1) % (2 * D)) == D) && (i >= 2 * D));
            if (ACT) begin : g_node
               assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-D]);
               assign ps[s+1][i] = ps[s][i] & ps[s][i-D];
            end else begin : g_wire
               assign gs[s+1][i] = gs[s][i];
               assign ps[s+1][i] = ps[s][i];
            end
         end
      end

      assign carry_o    = gs[NST];
      assign prop_all_o = ps[NST][WIDTH-1];
   end else begin : g_lf
      localparam int NST = LVLS;
      logic [WIDTH-1:0] gs [NST+1];
      logic [WIDTH-1:0] ps [NST+1];

      assign gs[0] = gen_i;
      assign ps[0] = prop_i;

      for (genvar s = 0; s < NST; s++) begin : g_stage
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            localparam bit ACT = (((i >> s) & 1) == 1);
            localparam int J   = ((i >> s) << s) - 1;
            if (ACT) begin : g_node
               assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][J]);
               assign ps[s+1][i] = ps[s][i] & ps[s][J];
            end else begin : g_wire
               assign gs[s+1][i] = gs[s][i];
               assign ps[s+1][i] = ps[s][i];
            end
         end
      end

      assign carry_o    = gs[NST];
      assign prop_all_o = ps[NST][WIDTH-1];
   end

   always_comb begin
      if (!$isunknown(prop_i)) begin
         AST_PROP_ALL: assert (prop_all_o == (&prop_i))
            else $error("group propagate disagrees with operand propagates"); // R3
      end
   end

endmodule

// File: rtl/mres_excess_one.sv
module mres_excess_one #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] sum_i,
   input  logic             inc_i,
   output logic [WIDTH-1:0] res_o
);

   logic [WIDTH-1:0] ones_below;

   assign ones_below[0] = 1'b1;
   for (genvar i = 1; i < WIDTH; i++) begin : g_chain
      assign ones_below[i] = ones_below[i-1] & sum_i[i-1];
   end

   assign res_o = sum_i ^ ({WIDTH{inc_i}} & ones_below);

   always_comb begin
      if (!$isunknown({sum_i, inc_i})) begin
         if (inc_i) begin
            AST_INCREMENT: assert (res_o == WIDTH'(sum_i + 1'b1))
               else $error("excess-one unit did not increment"); // R4
         end else begin
            AST_PASS_THROUGH: assert (res_o == sum_i)
               else $error("excess-one unit altered a passed sum"); // R5
         end
      end
   end

endmodule

// File: rtl/mres_add.sv
module mres_add
   import mres_pkg::*;
#(
   parameter int    WIDTH    = 16,
   parameter topo_e TOPOLOGY = TOPO_BRENT_KUNG
) (
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   output logic [WIDTH-1:0] res_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("mres_add: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] gen_w;
   logic [WIDTH-1:0] prop_w;
   logic [WIDTH-1:0] carry_w;
   logic             prop_all_w;
   logic [WIDTH-1:0] sum_w;
   logic             inc_w;

   assign gen_w  = opa_i & opb_i;
   assign prop_w = opa_i ^ opb_i;

   mres_prefix_tree #(
      .WIDTH    (WIDTH),
      .TOPOLOGY (TOPOLOGY)
   ) u_tree (
      .gen_i      (gen_w),
      .prop_i     (prop_w),
      .carry_o    (carry_w),
      .prop_all_o (prop_all_w)
   );

   assign sum_w = prop_w ^ {carry_w[WIDTH-2:0], 1'b0};
   assign inc_w = carry_w[WIDTH-1] | prop_all_w;

   mres_excess_one #(
      .WIDTH (WIDTH)
   ) u_fix (
      .sum_i (sum_w),
      .inc_i (inc_w),
      .res_o (res_o)
   );

   logic [WIDTH:0] wide_sum;
   assign wide_sum = {1'b0, opa_i} + {1'b0, opb_i};

   always_comb begin
      if (!$isunknown({opa_i, opb_i})) begin
         AST_CARRY_OUT: assert (carry_w[WIDTH-1] == wide_sum[WIDTH])
            else $error("prefix carry-out wrong"); // R4
         AST_PLAIN_SUM: assert (sum_w == wide_sum[WIDTH-1:0])
            else $error("prefix binary sum wrong"); // R5
         if (!((&opa_i) && (&opb_i))) begin
            AST_NO_ALL_ONES: assert (res_o != {WIDTH{1'b1}})
               else $error("result uses the all-ones zero"); // R2
         end
      end
   end

endmodule

// File: tb/mres_add_test.sv
module mres_add_test;
   import mres_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [3:0]  a4 = '0, b4 = '0;
   logic [4:0]  a5 = '0, b5 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic [31:0] a32 = '0, b32 = '0;
   logic [3:0]  r4bk, r4lf;
   logic [4:0]  r5bk, r5lf;
   logic [15:0] r16lf;
   logic [31:0] r32bk, r32lf;

   mres_add #(.WIDTH(4),  .TOPOLOGY(TOPO_BRENT_KUNG))     uut       (.opa_i(a4),  .opb_i(b4),  .res_o(r4bk));
   mres_add #(.WIDTH(4),  .TOPOLOGY(TOPO_LADNER_FISCHER)) uut_4lf   (.opa_i(a4),  .opb_i(b4),  .res_o(r4lf));
   mres_add #(.WIDTH(5),  .TOPOLOGY(TOPO_BRENT_KUNG))     uut_5bk   (.opa_i(a5),  .opb_i(b5),  .res_o(r5bk));
   mres_add #(.WIDTH(5),  .TOPOLOGY(TOPO_LADNER_FISCHER)) uut_5lf   (.opa_i(a5),  .opb_i(b5),  .res_o(r5lf));
   mres_add #(.WIDTH(16), .TOPOLOGY(TOPO_LADNER_FISCHER)) uut_16lf  (.opa_i(a16), .opb_i(b16), .res_o(r16lf));
   mres_add #(.WIDTH(32), .TOPOLOGY(TOPO_BRENT_KUNG))     uut_32bk  (.opa_i(a32), .opb_i(b32), .res_o(r32bk));
   mres_add #(.WIDTH(32), .TOPOLOGY(TOPO_LADNER_FISCHER)) uut_32lf  (.opa_i(a32), .opb_i(b32), .res_o(r32lf));

   task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic string case_tag(input longint unsigned s, input longint unsigned m);
      if (s == m) return "R3";
      if (s > m)  return "R4";
      return "R5";
   endfunction

   task automatic t_zero();
      @(negedge clk);
      a4 = '0; b4 = '0; a5 = '0; b5 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0;
      @(posedge clk);
      chk("R8 4bk zero", r4bk, 0);
      chk("R8 5lf zero", r5lf, 0);
      chk("R8 16lf zero", r16lf, 0);
      chk("R8 32bk zero", r32bk, 0);
   endtask

   task automatic t_exhaustive4();
      for (int x = 0; x < 15; x++) begin
         for (int y = 0; y < 15; y++) begin
            longint unsigned s = longint'(x + y);
            @(negedge clk);
            a4 = x[3:0]; b4 = y[3:0];
            @(posedge clk);
            chk({case_tag(s, 15), " R1 w4"}, r4bk, s % 15);
            chk("R7 w4 bk vs lf", r4lf, r4bk);
            chk("R2 w4", (r4bk == 4'hF), 0);
         end
      end
   endtask

   task automatic t_exhaustive5();
      for (int x = 0; x < 31; x++) begin
         for (int y = 0; y < 31; y++) begin
            longint unsigned s = longint'(x + y);
            @(negedge clk);
            a5 = x[4:0]; b5 = y[4:0];
            @(posedge clk);
            chk({case_tag(s, 31), " R1 w5"}, r5bk, s % 31);
            chk("R7 w5 bk vs lf", r5lf, r5bk);
         end
      end
   endtask

   task automatic t_alt_zero();
      for (int y = 0; y < 15; y++) begin
         @(negedge clk);
         a4 = 4'hF; b4 = y[3:0];
         @(posedge clk);
         chk("R6 w4 a=ones", r4bk, y);
         chk("R6 w4 lf a=ones", r4lf, y);
      end
      @(negedge clk);
      a32 = 32'h0000_1234; b32 = 32'hFFFF_FFFF;
      @(posedge clk);
      chk("R6 w32 b=ones", r32bk, 32'h0000_1234);
      @(negedge clk);
      a32 = 32'hFFFF_FFFF; b32 = 32'h0;
      @(posedge clk);
      chk("R6 w32 ones+0", r32lf, 0);
   endtask

   task automatic t_corners32();
      longint unsigned m = 64'hFFFF_FFFF;
      @(negedge clk);
      a32 = 32'hFFFF_FFFE; b32 = 32'hFFFF_FFFE;
      @(posedge clk);
      chk("R4 w32 max+max", r32bk, 64'hFFFF_FFFD);
      chk("R7 w32 max+max", r32lf, r32bk);
      @(negedge clk);
      a32 = 32'hFFFF_FFFE; b32 = 32'h1;
      @(posedge clk);
      chk("R3 w32 sum=m", r32bk, 0);
      chk("R3 w32 lf sum=m", r32lf, 0);
      @(negedge clk);
      a32 = 32'hAAAA_AAAA; b32 = 32'h5555_5555;
      @(posedge clk);
      chk("R3 w32 alt bits", r32lf, 0);
      @(negedge clk);
      a32 = 32'h8000_0000; b32 = 32'h8000_0000;
      @(posedge clk);
      chk("R4 w32 msb carry", r32bk, (64'h1_0000_0000) % m);
      @(negedge clk);
      a32 = 32'h1234_5678; b32 = 32'h0;
      @(posedge clk);
      chk("R8 w32 identity", r32bk, 32'h1234_5678);
      @(negedge clk);
      a16 = 16'hFFFE; b16 = 16'h0001;
      @(posedge clk);
      chk("R3 w16 sum=m", r16lf, 0);
   endtask

   task automatic t_random();
      for (int k = 0; k < 600; k++) begin
         longint unsigned x16 = $urandom % 65535;
         longint unsigned y16 = $urandom % 65535;
         longint unsigned x32 = $urandom % 32'hFFFF_FFFF;
         longint unsigned y32 = $urandom % 32'hFFFF_FFFF;
         @(negedge clk);
         a16 = x16[15:0]; b16 = y16[15:0];
         a32 = x32[31:0]; b32 = y32[31:0];
         @(posedge clk);
         chk("R1 w16 random", r16lf, (x16 + y16) % 65535);
         chk("R1 w32 random", r32bk, (x32 + y32) % 64'hFFFF_FFFF);
         chk("R7 w32 random", r32lf, r32bk);
         chk("R2 w32 random", (r32bk == 32'hFFFF_FFFF), 0);
      end
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      t_zero();
      t_exhaustive4();
      t_exhaustive5();
      t_alt_zero();
      t_corners32();
      t_random();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule